// File: doc/BRIEF.md
# Masked Sticky Interrupt Pending Controller

This block gathers a set of level-sensitive interrupt request lines into one processor interrupt. Every line that is seen high at a clock edge latches its pending bit. The pending bit stays set after the line falls, until software clears it with a write-one-to-clear acknowledge. The clear cannot remove a bit whose line is still high, because the line sets the bit again at the same edge. The interrupt output is raised while any pending bit is also enabled in a mask register.

A small register port with a 3-bit address gives software access to the mask, the pending bits and the raw line levels. Each line also has a 64-bit counter of its rising edges. Software reads a counter by writing the line number to an index register and then reading a low word and a high word. The line count, the data width, the counter width and the choice between a registered and a combinational output are parameters.

Top module: `irq_pend_ctrl`

## Requirements
- R1: The raw-state register takes each line's level at every clock edge, with bit i holding line i, and reads back at address 2.
- R2: A pending bit stays set after its line falls low, until an acknowledge write clears it.
- R3: A line sampled high at a clock edge sets its pending bit at that edge, even when an acknowledge in the same cycle targets that bit.
- R4: A write to address 1 clears every pending bit whose written data bit is 1 and whose line is low. Bits written as 0 keep their value.
- R5: The interrupt output is registered. After each clock edge it equals the OR of (pending AND mask) as those registers stand after that edge, so it follows a line, mask or acknowledge change by one clock.
- R6: A write to address 0 replaces the whole mask with the written data, with bit i enabling line i. The mask reads back at address 0.
- R7: Reset clears the mask, pending, raw-state and counter-index registers, every per-line counter and the interrupt output.
- R8: Each line's 64-bit counter adds one when the line is high at an edge and was low at the previous edge. Further cycles with the line held high do not count.
- R9: Address map: 0 is the mask, 1 is pending on read and acknowledge on write, 2 is raw state, 3 is the counter index (its low 5 bits, read back zero-extended), 4 is the counter low word, 5 is the counter high word, and 6 and 7 read as zero.
- R10: Writing the index at address 3 selects a line. Address 4 then returns bits 31:0 of that line's counter and address 5 returns bits 63:32.
- R11: Writes to addresses 2, 4, 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Level-sensitive interrupt request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The bound checker checks on every cycle that raw state follows the lines and that pending bits stay set unless acknowledged. It also checks that a high line always sets its pending bit, that an acknowledged bit with a low line clears, that a mask write is taken whole, and that the interrupt output matches pending AND mask. The edge-only counting of the counters, the index and high/low word selection, the address map, the writes to read-only addresses that must change nothing, and reset in the middle of activity are shown only by the bench. The bench does this through directed scenarios and through a behavioural model that is compared on every clock.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
package irq_pend_pkg;

   localparam int unsigned REG_DW = 32;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_MASK = 3'd0,
      RA_PEND = 3'd1,
      RA_RAW  = 3'd2,
      RA_CIDX = 3'd3,
      RA_CLO  = 3'd4,
      RA_CHI  = 3'd5
   } reg_addr_e;

   typedef struct packed {
      logic mask_we;
      logic ack_we;
      logic idx_we;
   } wr_dec_t;

   function automatic wr_dec_t decode_wr(input logic wr, input logic [REG_AW-1:0] addr);
      wr_dec_t d;
      d.mask_we = wr && (addr == RA_MASK);
      d.ack_we  = wr && (addr == RA_PEND);
      d.idx_we  = wr && (addr == RA_CIDX);
      return d;
   endfunction

endpackage

// File: rtl/irq_line_slice.sv
`timescale 1ns/1ps
module irq_line_slice #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   input  logic             clr_i,
   output logic             raw_o,
   output logic             pend_o,
   output logic             pend_nxt_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic             raw_q;
   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;

   // clear first, then the live level re-asserts
   always_comb begin
      pend_nxt_o = (pend_q & ~clr_i) | line_i;
      rise       = line_i & ~raw_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= 1'b0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         raw_q  <= line_i;
         pend_q <= pend_nxt_o;
         if (rise) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign raw_o  = raw_q;
   assign pend_o = pend_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/irq_reg_port.sv
`timescale 1ns/1ps
module irq_reg_port
   import irq_pend_pkg::*;
#(
   parameter int unsigned N_LINES = 32,
   parameter int unsigned DW      = 32,
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [REG_AW-1:0]        addr_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic [N_LINES-1:0]       pend_i,
   input  logic [N_LINES-1:0]       raw_i,
   input  logic [N_LINES*CNT_W-1:0] cnt_flat_i,
   output logic [N_LINES-1:0]       mask_o,
   output logic [N_LINES-1:0]       mask_nxt_o,
   output logic [N_LINES-1:0]       clr_o,
   output logic [DW-1:0]            rdata_o
);

   localparam int unsigned TAB_D = 1 << IDX_W;

   wr_dec_t              dec;
   logic [N_LINES-1:0]   mask_q;
   logic [IDX_W-1:0]     idx_q;
   logic [CNT_W-1:0]     cnt_tab [TAB_D];
   logic [CNT_W-1:0]     cnt_sel;
   logic [2*DW-1:0]      sel_wide;

   assign dec        = decode_wr(wr_i, addr_i);
   assign mask_nxt_o = dec.mask_we ? wdata_i[N_LINES-1:0] : mask_q;
   assign clr_o      = dec.ack_we ? wdata_i[N_LINES-1:0] : '0;
   assign mask_o     = mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         idx_q  <= '0;
      end else begin
         mask_q <= mask_nxt_o;
         if (dec.idx_we) idx_q <= wdata_i[IDX_W-1:0];
      end
   end

   // index table padded to a power of two so any index is legal
   for (genvar j = 0; j < TAB_D; j++) begin : g_tab
      if (j < N_LINES) begin : g_live
         assign cnt_tab[j] = cnt_flat_i[j*CNT_W +: CNT_W];
      end else begin : g_pad
         assign cnt_tab[j] = '0;
      end
   end

   assign cnt_sel = cnt_tab[idx_q];

   if (CNT_W == 2*DW) begin : g_full
      assign sel_wide = cnt_sel;
   end else begin : g_pad_w
      assign sel_wide = {{(2*DW-CNT_W){1'b0}}, cnt_sel};
   end

   always_comb begin
      unique case (addr_i)
         RA_MASK: rdata_o = DW'(mask_q);
         RA_PEND: rdata_o = DW'(pend_i);
         RA_RAW:  rdata_o = DW'(raw_i);
         RA_CIDX: rdata_o = DW'(idx_q);
         RA_CLO:  rdata_o = sel_wide[DW-1:0];
         RA_CHI:  rdata_o = sel_wide[2*DW-1:DW];
         default: rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/irq_pend_ctrl.sv
`timescale 1ns/1ps
module irq_pend_ctrl
   import irq_pend_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned CNT_W     = 64,
   parameter bit          IRQ_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines_i,
   input  logic                 reg_wr_i,
   input  logic [REG_AW-1:0]    reg_addr_i,
   input  logic [REG_DW-1:0]    reg_wdata_i,
   output logic [REG_DW-1:0]    reg_rdata_o,
   output logic                 irq_o
);

   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   initial begin
      assert (NUM_LINES >= 1 && NUM_LINES <= REG_DW)
         else $error("NUM_LINES must lie in 1..%0d", REG_DW);
      assert (CNT_W >= 1 && CNT_W <= 2*REG_DW)
         else $error("CNT_W must lie in 1..%0d", 2*REG_DW);
   end

   logic [NUM_LINES-1:0]       raw_vec;
   logic [NUM_LINES-1:0]       pend_vec;
   logic [NUM_LINES-1:0]       pend_nxt;
   logic [NUM_LINES-1:0]       clr_vec;
   logic [NUM_LINES-1:0]       mask_q;
   logic [NUM_LINES-1:0]       mask_nxt;
   logic [NUM_LINES*CNT_W-1:0] cnt_flat;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_line_slice #(.CNT_W(CNT_W)) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_i     (irq_lines_i[i]),
         .clr_i      (clr_vec[i]),
         .raw_o      (raw_vec[i]),
         .pend_o     (pend_vec[i]),
         .pend_nxt_o (pend_nxt[i]),
         .cnt_o      (cnt_flat[i*CNT_W +: CNT_W])
      );
   end

   irq_reg_port #(
      .N_LINES (NUM_LINES),
      .DW      (REG_DW),
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W)
   ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (reg_wr_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .pend_i     (pend_vec),
      .raw_i      (raw_vec),
      .cnt_flat_i (cnt_flat),
      .mask_o     (mask_q),
      .mask_nxt_o (mask_nxt),
      .clr_o      (clr_vec),
      .rdata_o    (reg_rdata_o)
   );

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(pend_nxt & mask_nxt);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |(pend_vec & mask_q);
   end

endmodule

// File: rtl/irq_pend_ctrl_chk.sv
`timescale 1ns/1ps
module irq_pend_ctrl_chk
   import irq_pend_pkg::*;
#(
   parameter int unsigned N = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      lines,
   input logic              wr,
   input logic [REG_AW-1:0] addr,
   input logic [REG_DW-1:0] wdata,
   input logic [N-1:0]      pend,
   input logic [N-1:0]      mask,
   input logic [N-1:0]      raw,
   input logic              irq
);

   logic         seen;
   logic [N-1:0] ackv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   assign ackv = (wr && addr == RA_PEND) ? wdata[N-1:0] : '0;

   p_raw_follows_r1: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      raw == $past(lines));

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (pend & $past(pend & ~ackv)) == $past(pend & ~ackv));

   p_line_sets_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (pend & $past(lines)) == $past(lines));

   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (wr && addr == RA_PEND) |=> ((pend & $past(wdata[N-1:0] & ~lines)) == '0));

   p_irq_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(pend & mask));

   p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (wr && addr == RA_MASK) |=> (mask == $past(wdata[N-1:0])));

endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.N(NUM_LINES)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .lines (irq_lines_i),
   .wr    (reg_wr_i),
   .addr  (reg_addr_i),
   .wdata (reg_wdata_i),
   .pend  (pend_vec),
   .mask  (mask_q),
   .raw   (raw_vec),
   .irq   (irq_o)
);

// File: tb/sim_irq_pend_ctrl.sv
`timescale 1ns/1ps
module sim_irq_pend_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lines = '0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;

   // behavioural reference state
   logic [31:0]     m_mask, m_pend, m_raw;
   logic            m_irq;
   int              m_idx;
   longint unsigned m_cnt [32];

   always #2 clk = ~clk;

   irq_pend_ctrl u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lines_i (lines),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_mask;
         3'd1: return m_pend;
         3'd2: return m_raw;
         3'd3: return 32'(m_idx);
         3'd4: return m_cnt[m_idx][31:0];
         3'd5: return m_cnt[m_idx][63:32];
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_step();
      if (!rst_n) begin
         m_mask = '0; m_pend = '0; m_raw = '0; m_irq = 1'b0; m_idx = 0;
         foreach (m_cnt[k]) m_cnt[k] = 0;
      end else begin
         logic [31:0] ack;
         ack = (wr && addr == 3'd1) ? wdata : 32'h0;
         if (wr && addr == 3'd0) m_mask = wdata;
         if (wr && addr == 3'd3) m_idx = int'(wdata[4:0]);
         for (int k = 0; k < 32; k++)
            if (lines[k] && !m_raw[k]) m_cnt[k] = m_cnt[k] + 1;
         m_pend = (m_pend & ~ack) | lines;
         m_raw  = lines;
         m_irq  = (m_pend & m_mask) != 0;
      end
   endtask

   task automatic compare();
      string tag;
      case (addr)
         3'd0: tag = "R6 mask read";
         3'd1: tag = "R2 pending read";
         3'd2: tag = "R1 raw read";
         3'd3: tag = "R10 index read";
         3'd4, 3'd5: tag = "R8 counter word";
         default: tag = "R9 unmapped read";
      endcase
      chk(tag, rdata, model_read(addr));
      chk("R5 irq", {31'h0, irq}, {31'h0, m_irq});
   endtask

   // apply one cycle of inputs, then update model and compare just after the edge
   task automatic drive(input logic [31:0] l, input logic w, input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      lines = l; wr = w; addr = a; wdata = d;
      @(posedge clk);
      #1;
      model_step();
      compare();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lines = '0; wr = 1'b0; addr = '0; wdata = '0;
      @(posedge clk); #1; model_step();
      @(posedge clk); #1; model_step();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reset_checks();
      drive(0, 0, 3'd0, 0); chk("R7 mask after reset", rdata, 32'h0);
      chk("R7 irq after reset", {31'h0, irq}, 32'h0);
      drive(0, 0, 3'd1, 0); chk("R7 pending after reset", rdata, 32'h0);
      drive(0, 0, 3'd2, 0); chk("R7 raw after reset", rdata, 32'h0);
      drive(0, 0, 3'd3, 0); chk("R7 index after reset", rdata, 32'h0);
      for (int k = 0; k < 32; k += 7) begin
         drive(0, 1, 3'd3, 32'(k));
         drive(0, 0, 3'd4, 0); chk("R7 counter low after reset", rdata, 32'h0);
         drive(0, 0, 3'd5, 0); chk("R7 counter high after reset", rdata, 32'h0);
      end
      drive(0, 1, 3'd3, 0);
   endtask

   task automatic random_phase(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         logic [31:0] l;
         l = $urandom & $urandom & $urandom;
         if (($urandom % 4) != 0) l = lines;   // hold levels for a while
         drive(l, ($urandom % 3) == 0, 3'($urandom), $urandom);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      reset_checks();

      drive(32'h5, 0, 3'd1, 0);  chk("R3 line sets pending", rdata, 32'h5);
      chk("R5 masked off keeps irq low", {31'h0, irq}, 32'h0);
      drive(32'h0, 0, 3'd1, 0);  chk("R2 pending sticky after drop", rdata, 32'h5);
      drive(32'h0, 0, 3'd2, 0);  chk("R1 raw follows low lines", rdata, 32'h0);
      drive(32'h0, 1, 3'd1, 32'h1); chk("R4 ack clears bit 0 only", rdata, 32'h4);
      drive(32'h4, 1, 3'd1, 32'h4); chk("R3 high line beats ack", rdata, 32'h4);
      drive(32'h0, 1, 3'd0, 32'h4); chk("R5 irq one clock after mask", {31'h0, irq}, 32'h1);
      drive(32'h0, 0, 3'd0, 0);  chk("R6 mask readback", rdata, 32'h4);
      drive(32'h0, 1, 3'd1, 32'h4); chk("R4 ack with line low", rdata, 32'h0);
      chk("R5 irq drops after ack", {31'h0, irq}, 32'h0);
      drive(32'h0, 1, 3'd0, 32'hFFFF_0000);
      drive(32'h0, 0, 3'd0, 0);  chk("R6 mask fully replaced", rdata, 32'hFFFF_0000);

      drive(32'h8, 0, 3'd0, 0);
      drive(32'h8, 0, 3'd0, 0);
      drive(32'h8, 0, 3'd0, 0);
      drive(32'h0, 0, 3'd0, 0);
      drive(32'h8, 0, 3'd0, 0);
      drive(32'h0, 0, 3'd0, 0);
      drive(32'h0, 1, 3'd3, 32'd3);
      drive(32'h0, 0, 3'd4, 0);  chk("R8 line 3 counts edges only", rdata, 32'd2);
      drive(32'h0, 0, 3'd5, 0);  chk("R10 high word of line 3", rdata, 32'd0);
      drive(32'h0, 0, 3'd3, 0);  chk("R10 index readback", rdata, 32'd3);
      drive(32'h0, 1, 3'd3, 32'd2);
      drive(32'h0, 0, 3'd4, 0);  chk("R8 line 2 edge count", rdata, 32'd2);

      drive(32'h0, 1, 3'd2, 32'hFFFF_FFFF);
      drive(32'h0, 0, 3'd2, 0);  chk("R11 raw write ignored", rdata, 32'h0);
      drive(32'h0, 1, 3'd4, 32'hFFFF_FFFF);
      drive(32'h0, 0, 3'd4, 0);  chk("R11 counter write ignored", rdata, 32'd2);
      drive(32'h0, 1, 3'd6, 32'hFFFF_FFFF);
      drive(32'h0, 0, 3'd6, 0);  chk("R9 address 6 reads zero", rdata, 32'h0);
      drive(32'h0, 0, 3'd7, 0);  chk("R9 address 7 reads zero", rdata, 32'h0);
      drive(32'h0, 0, 3'd1, 0);  chk("R11 pending untouched by stray writes", rdata, 32'h8);

      random_phase(3000);
      do_reset();
      reset_checks();
      random_phase(3000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule